// File: doc/BRIEF.md
# AAL1 Structured-Mode Pointer Synchronizer

This block takes a byte stream of 48-octet AAL1 cells that use the structured format. It checks each cell's header octet, which holds the sequence count and its protection, and gives one status result per cell. Cells whose count is even and whose CSI bit is set carry a structure pointer in the first octet after the header. The block reads that pointer and uses it to place each new buffer on a structured-block boundary. The data octets go out on a byte-wide write port: 46 per cell when a pointer octet is present, 47 otherwise.

After reset the block hunts. It needs a cell with a good header and a valid pointer. It then skips the number of data octets the pointer gives, and that count may run into the following cell. The octet at the boundary is written as byte zero of a new buffer, and the block is then in sync. In sync, a cell whose header is corrupt or whose sequence count is not the expected one closes the buffer with an error strobe, and the block returns to the hunt.

Top module: `aal1_sp_sync`

## Requirements
- R1: The header octet is laid out as CSI in bit 7, the sequence count in bits 6:4, a CRC-3 in bits 3:1 and an even-parity bit in bit 0. The CRC-3 is the remainder of bits 7:4 times x^3 divided by x^3+x+1, and the parity makes the whole octet even. One cycle after each header octet, `stsValid` pulses for one cycle. `stsHdrOk` is high only if both the CRC and the parity are correct.
- R2: Outside hunt, the expected count is the previous good header's count plus 1, modulo 8. `stsSeqOk` reports whether the cell's count matches it. In hunt, `stsSeqOk` reads 1.
- R3: A cell whose header is good, with CSI=1 and an even count, carries a pointer in the octet right after the header and delivers 46 data octets. Every other cell delivers 47 data octets. A pointer octet is never written.
- R4: The pointer value is in bits 6:0, and bit 7 makes the pointer octet even parity. A pointer is valid only if its parity is correct and its value is at most 93. The value 127 (no boundary), any other value above 93, and any pointer with bad parity all leave the block in hunt.
- R5: After reset the block hunts with `synced` low. No write and no status is pending. Data octets that arrive in hunt are discarded.
- R6: When a valid pointer p arrives in hunt, the next p data octets are discarded, even across cell boundaries. The data octet after them is written with `wrFirst`=1, and `synced` rises in the same cycle.
- R7: In sync, every data octet is written in arrival order, one cycle after it is accepted, with `wrFirst`=0. A cycle with `inValid` low produces no write and no status.
- R8: In sync, a header that is bad or carries an unexpected count pulses `closeErr` together with its status. `synced` then drops, and data is discarded until a new valid pointer arrives. The same fault during the skip phase returns to hunt without `closeErr`.
- R9: Pointers that arrive while the block is skipping or in sync do not change the alignment.
- R10: A cell that causes a return to hunt but has a good header can supply the pointer for the new alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input octet valid |
| inFirst | input | 1 | Marks the header octet of a cell |
| inByte | input | 8 | Input octet |
| wrValid | output | 1 | Buffer write strobe |
| wrData | output | 8 | Octet written to the buffer |
| wrFirst | output | 1 | Written octet is byte zero of a new buffer |
| closeErr | output | 1 | Buffer closed on a sequence or header error |
| stsValid | output | 1 | Per-cell header status strobe |
| stsHdrOk | output | 1 | Header CRC and parity both correct |
| stsSeqOk | output | 1 | Sequence count as expected |
| synced | output | 1 | Block is in sync and writing |

## Verification
The bench targets these corner cases:
- A pointer of 93. It skips a full 46+47-octet span and jumps over the pointer octet of the third cell. An off-by-one counter would open the buffer one octet early or late.
- The value 127, an out-of-range value and bad parity. A design that accepts any of them would sync on a non-boundary.
- A pointer arriving in sync. A design that re-aligns on it would restart the buffer.
- A count fault during skip. This must not raise `closeErr`.
- A count fault in a cell that itself carries pointer 0. The next data octet must open the new buffer at once.

// File: rtl/aal1_sp_pkg.sv
package aal1_sp_pkg;

  localparam int SC_W    = 3;
  localparam int PTR_W   = 7;
  localparam int PTR_MAX = 93;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_SKIP = 2'd1,
    ST_SYNC = 2'd2
  } syncState_e;

  typedef struct packed {
    logic wrEn;
    logic wrFirst;
    logic closeErr;
    logic stsEn;
    logic stsHdrOk;
    logic stsSeqOk;
  } ctrlStrobes_t;

  // Remainder of (d * x^3) mod (x^3 + x + 1), computed serially MSB first.
  function automatic logic [2:0] crc3(input logic [3:0] d);
    logic [2:0] rem;
    logic fb;
    rem = 3'b000;
    for (int i = 3; i >= 0; i--) begin
      fb  = d[i] ^ rem[2];
      rem = {rem[1:0], 1'b0} ^ (fb ? 3'b011 : 3'b000);
    end
    return rem;
  endfunction

endpackage

// File: rtl/aal1_sp_ctrl.sv
module aal1_sp_ctrl
  import aal1_sp_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int CNT_W   = SC_W,
  parameter int OFF_W   = PTR_W,
  parameter int OFF_MAX = PTR_MAX
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inFirst,
  input  logic [BYTE_W-1:0] inByte,
  output ctrlStrobes_t      strobes,
  output logic              syncedState
);

  localparam int CSI_BIT = BYTE_W - 1;
  localparam int SC_LSB  = CSI_BIT - CNT_W;

  syncState_e       state, stateNxt;
  logic [CNT_W-1:0] expSc, expScNxt;
  logic [OFF_W-1:0] skipCnt, skipCntNxt;
  logic             ptrNext, ptrNextNxt;

  logic             hdrCsi;
  logic [CNT_W-1:0] hdrSc;
  logic [2:0]       hdrCrc;
  logic             hdrGood, seqGood;
  logic [OFF_W-1:0] ptrVal;
  logic             ptrValid;

  always_comb begin
    hdrCsi   = inByte[CSI_BIT];
    hdrSc    = inByte[CSI_BIT-1:SC_LSB];
    hdrCrc   = inByte[3:1];
    hdrGood  = (hdrCrc == crc3({hdrCsi, hdrSc})) && !(^inByte);
    seqGood  = (state == ST_HUNT) || (hdrSc == expSc);
    ptrVal   = inByte[OFF_W-1:0];
    ptrValid = !(^inByte) && (ptrVal <= OFF_W'(OFF_MAX));
  end

  always_comb begin
    stateNxt   = state;
    expScNxt   = expSc;
    skipCntNxt = skipCnt;
    ptrNextNxt = ptrNext;
    strobes    = '0;
    if (inValid) begin
      if (inFirst) begin
        strobes.stsEn    = 1'b1;
        strobes.stsHdrOk = hdrGood;
        strobes.stsSeqOk = seqGood;
        if (state != ST_HUNT && !(hdrGood && seqGood)) begin
          strobes.closeErr = (state == ST_SYNC);
          stateNxt         = ST_HUNT;
        end
        if (hdrGood) expScNxt = hdrSc + 1'b1;
        ptrNextNxt = hdrGood && hdrCsi && !hdrSc[0];
      end else if (ptrNext) begin
        ptrNextNxt = 1'b0;
        if (state == ST_HUNT && ptrValid) begin
          stateNxt   = ST_SKIP;
          skipCntNxt = ptrVal;
        end
      end else begin
        unique case (state)
          ST_SKIP: begin
            if (skipCnt == '0) begin
              strobes.wrEn    = 1'b1;
              strobes.wrFirst = 1'b1;
              stateNxt        = ST_SYNC;
            end else begin
              skipCntNxt = skipCnt - 1'b1;
            end
          end
          ST_SYNC: strobes.wrEn = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      expSc   <= '0;
      skipCnt <= '0;
      ptrNext <= 1'b0;
    end else begin
      state   <= stateNxt;
      expSc   <= expScNxt;
      skipCnt <= skipCntNxt;
      ptrNext <= ptrNextNxt;
    end
  end

  assign syncedState = (state == ST_SYNC);

endmodule

// File: rtl/aal1_sp_datapath.sv
module aal1_sp_datapath
  import aal1_sp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] inByte,
  input  ctrlStrobes_t      strobes,
  output logic              wrValid,
  output logic [BYTE_W-1:0] wrData,
  output logic              wrFirst,
  output logic              closeErr,
  output logic              stsValid,
  output logic              stsHdrOk,
  output logic              stsSeqOk
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrValid  <= 1'b0;
      wrData   <= '0;
      wrFirst  <= 1'b0;
      closeErr <= 1'b0;
      stsValid <= 1'b0;
      stsHdrOk <= 1'b0;
      stsSeqOk <= 1'b0;
    end else begin
      wrValid  <= strobes.wrEn;
      wrFirst  <= strobes.wrFirst;
      closeErr <= strobes.closeErr;
      stsValid <= strobes.stsEn;
      stsHdrOk <= strobes.stsHdrOk;
      stsSeqOk <= strobes.stsSeqOk;
      if (strobes.wrEn) wrData <= inByte;
    end
  end

endmodule

// File: rtl/aal1_sp_sync.sv
module aal1_sp_sync
  import aal1_sp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inFirst,
  input  logic [BYTE_W-1:0] inByte,
  output logic              wrValid,
  output logic [BYTE_W-1:0] wrData,
  output logic              wrFirst,
  output logic              closeErr,
  output logic              stsValid,
  output logic              stsHdrOk,
  output logic              stsSeqOk,
  output logic              synced
);

  ctrlStrobes_t strobes;

  aal1_sp_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inFirst    (inFirst),
    .inByte     (inByte),
    .strobes    (strobes),
    .syncedState(synced)
  );

  aal1_sp_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .inByte  (inByte),
    .strobes (strobes),
    .wrValid (wrValid),
    .wrData  (wrData),
    .wrFirst (wrFirst),
    .closeErr(closeErr),
    .stsValid(stsValid),
    .stsHdrOk(stsHdrOk),
    .stsSeqOk(stsSeqOk)
  );

endmodule

// File: rtl/aal1_sp_checker.sv
module aal1_sp_checker (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic wrValid,
  input logic wrFirst,
  input logic closeErr,
  input logic stsValid,
  input logic stsHdrOk,
  input logic stsSeqOk,
  input logic synced
);

  AST_WRITE_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> synced) else $error("write outside sync"); // R7

  AST_FIRST_IS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrFirst |-> wrValid) else $error("first without write"); // R6

  AST_SYNC_ENTRY_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(synced) |-> wrFirst) else $error("sync entered without opening"); // R6

  AST_CLOSE_LEAVES_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    closeErr |-> (!synced && $past(synced))) else $error("close without leaving sync"); // R8

  AST_CLOSE_WITH_BAD_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    closeErr |-> (stsValid && !(stsHdrOk && stsSeqOk))) else $error("close without fault"); // R8

  AST_STATUS_NOT_DATA: assert property (@(posedge clk) disable iff (!rstN)
    stsValid |-> !wrValid) else $error("header written as data"); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!wrValid && !stsValid)) else $error("output on idle cycle"); // R7

endmodule

bind aal1_sp_sync aal1_sp_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .wrValid (wrValid),
  .wrFirst (wrFirst),
  .closeErr(closeErr),
  .stsValid(stsValid),
  .stsHdrOk(stsHdrOk),
  .stsSeqOk(stsSeqOk),
  .synced  (synced)
);

// File: tb/tb_aal1_sp_sync.sv
module tb_aal1_sp_sync;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rstN;
  logic inValid, inFirst;
  logic [7:0] inByte;
  logic wrValid, wrFirst, closeErr, stsValid, stsHdrOk, stsSeqOk, synced;
  logic [7:0] wrData;

  always #(CLK_PERIOD/2) clk = ~clk;

  aal1_sp_sync dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFirst(inFirst), .inByte(inByte),
    .wrValid(wrValid), .wrData(wrData), .wrFirst(wrFirst), .closeErr(closeErr),
    .stsValid(stsValid), .stsHdrOk(stsHdrOk), .stsSeqOk(stsSeqOk), .synced(synced)
  );

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit finished = 0;

  // stimulus queues
  bit   qFirst[$];
  byte  qByte[$];
  byte  dataCtr = 8'h10;

  // reference model state: 0 hunt, 1 skip, 2 sync
  int   mMode = 0;
  int   mExpSc = 0;
  int   mSkip = 0;
  bit   mPtrNext = 0;

  // expectations for the next sample
  bit eWr, eFirst, eClose, eSts, eHdr, eSeq, eSync;
  byte eData;
  string eTag = "R5";
  string scen = "reset";

  // CRC-3 by polynomial long division on a 7-bit value
  function automatic bit [2:0] refCrc(bit [3:0] m);
    bit [6:0] v;
    v = {m, 3'b000};
    for (int i = 6; i >= 3; i--)
      if (v[i]) v = v ^ (7'b1011 << (i - 3));
    return v[2:0];
  endfunction

  function automatic byte mkHeader(int sc, bit csi, bit badCrc);
    bit [7:0] h;
    h[7]   = csi;
    h[6:4] = sc[2:0];
    h[3:1] = refCrc({csi, sc[2:0]}) ^ (badCrc ? 3'b001 : 3'b000);
    h[0]   = ^h[7:1];
    return h;
  endfunction

  function automatic byte mkPtr(int p, bit badPar);
    bit [7:0] o;
    o[6:0] = p[6:0];
    o[7]   = (^o[6:0]) ^ badPar;
    return o;
  endfunction

  task automatic addCell(int sc, bit csi, int ptr, bit badPar, bit badCrc);
    int nData;
    qFirst.push_back(1'b1);
    qByte.push_back(mkHeader(sc, csi, badCrc));
    nData = 47;
    if (csi && (sc % 2 == 0)) begin
      qFirst.push_back(1'b0);
      qByte.push_back(mkPtr(ptr, badPar));
      nData = 46;
    end
    for (int i = 0; i < nData; i++) begin
      qFirst.push_back(1'b0);
      qByte.push_back(dataCtr);
      dataCtr++;
    end
  endtask

  task automatic modelStep(bit v, bit f, byte b);
    bit [7:0] ub;
    bit hOk, sOk, pOk;
    int sc;
    ub = b;
    eWr = 0; eFirst = 0; eClose = 0; eSts = 0; eHdr = 0; eSeq = 0; eData = 0;
    eTag = "R7";
    if (v) begin
      if (f) begin
        sc  = ub[6:4];
        hOk = (ub[3:1] == refCrc(ub[7:4])) && ((^ub) == 1'b0);
        sOk = (mMode == 0) ? 1'b1 : (sc == mExpSc);
        eSts = 1; eHdr = hOk; eSeq = sOk;
        eTag = (mMode == 0) ? "R1" : "R2";
        if (mMode != 0 && !(hOk && sOk)) begin
          eClose = (mMode == 2);
          eTag = "R8";
          mMode = 0;
        end
        if (hOk) mExpSc = (sc + 1) % 8;
        mPtrNext = hOk && ub[7] && (sc % 2 == 0);
      end else if (mPtrNext) begin
        mPtrNext = 0;
        eTag = (mMode == 0) ? "R4" : "R9";
        pOk = ((^ub) == 1'b0) && (ub[6:0] <= 93);
        if (mMode == 0 && pOk) begin
          mMode = 1;
          mSkip = ub[6:0];
        end
      end else begin
        if (mMode == 0) eTag = "R5";
        else if (mMode == 1) begin
          eTag = "R6";
          if (mSkip == 0) begin
            eWr = 1; eFirst = 1; eData = b; mMode = 2;
          end else mSkip--;
        end else begin
          eWr = 1; eData = b;
        end
      end
    end
    eSync = (mMode == 2);
  endtask

  task automatic compareOutputs();
    bit bad;
    testsRun++;
    bad = (wrValid !== eWr) || (wrFirst !== (eWr && eFirst)) ||
          (eWr && (wrData !== eData)) || (closeErr !== eClose) ||
          (stsValid !== eSts) || (eSts && ((stsHdrOk !== eHdr) || (stsSeqOk !== eSeq))) ||
          (synced !== eSync);
    if (bad) begin
      testsFailed++;
      $display("FAIL %s [%s] actual wr=%0b d=%02h f=%0b cl=%0b st=%0b h=%0b s=%0b sy=%0b expected wr=%0b d=%02h f=%0b cl=%0b st=%0b h=%0b s=%0b sy=%0b",
               eTag, scen, wrValid, wrData, wrFirst, closeErr, stsValid, stsHdrOk, stsSeqOk, synced,
               eWr, eData, eWr && eFirst, eClose, eSts, eHdr, eSeq, eSync);
    end
  endtask

  task automatic stepCycle(bit v, bit f, byte b);
    @(negedge clk);
    compareOutputs();
    inValid = v; inFirst = f; inByte = b;
    modelStep(v, f, b);
  endtask

  int gapCtr = 0;
  task automatic runQueue();
    while (qByte.size() > 0) begin
      stepCycle(1'b1, qFirst.pop_front(), qByte.pop_front());
      gapCtr++;
      if (gapCtr % 11 == 0) stepCycle(1'b0, 1'b0, 8'h00);  // R7 idle gap
    end
    stepCycle(1'b0, 1'b0, 8'h00);
    stepCycle(1'b0, 1'b0, 8'h00);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inFirst = 1'b0; inByte = 8'h00;
    eWr = 0; eFirst = 0; eClose = 0; eSts = 0; eHdr = 0; eSeq = 0; eSync = 0; eData = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R5: reset state observed on the first compare
    scen = "R5 reset and hunt";
    stepCycle(1'b0, 1'b0, 8'h00);
    addCell(1, 0, 0, 0, 0);
    addCell(2, 0, 0, 0, 0);
    addCell(3, 0, 0, 0, 0);
    runQueue();

    // R4: invalid pointers keep hunting
    scen = "R4 invalid pointers";
    addCell(4, 1, 127, 0, 0);
    addCell(5, 0, 0, 0, 0);
    addCell(6, 1, 10, 1, 0);
    addCell(7, 0, 0, 0, 0);
    addCell(0, 1, 100, 0, 0);
    runQueue();

    // R6 alignment with pointer 5, R3 pointer octet, R9 later pointer ignored
    scen = "R6 ptr5 R9 ignore";
    addCell(1, 0, 0, 0, 0);
    addCell(2, 1, 5, 0, 0);
    addCell(3, 0, 0, 0, 0);
    addCell(4, 1, 40, 0, 0);
    addCell(5, 0, 0, 0, 0);
    addCell(6, 1, 0, 0, 0);
    runQueue();

    // R8 count jump with R10 immediate resync, then R1 bad CRC closes
    scen = "R8 R10 mismatch";
    addCell(2, 1, 0, 0, 0);
    addCell(3, 0, 0, 0, 0);
    addCell(4, 0, 0, 0, 1);
    addCell(5, 0, 0, 0, 0);
    runQueue();

    // R6 maximum offset spanning two cells
    scen = "R6 ptr93 span";
    addCell(0, 1, 93, 0, 0);
    addCell(1, 0, 0, 0, 0);
    addCell(2, 1, 127, 0, 0);
    addCell(3, 0, 0, 0, 0);
    runQueue();

    // R8 fault during skip: back to hunt with no close
    scen = "R8 skip fault";
    addCell(5, 0, 0, 0, 0);
    addCell(6, 1, 60, 0, 0);
    addCell(0, 1, 70, 0, 0);
    addCell(1, 0, 0, 0, 0);
    addCell(2, 1, 0, 0, 0);
    addCell(3, 0, 0, 0, 0);
    runQueue();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule